// File: doc/BRIEF.md
# Trigger Fire Arbiter

This block sits after the per-trigger comparators of a hart's debug trigger unit. Every cycle it receives one match pulse per trigger together with that trigger's priority class, its action (take a breakpoint exception or enter Debug Mode), and a link bit that joins it to the next trigger into a chain. It works out which chains are complete, gives each chain the weakest class among its members, and removes chains that may not fire at this moment. It then keeps only the strongest class that still has a candidate.

For one cycle it raises the breakpoint request, the debug-entry request, or both. When both are raised, it also signals which of them the core must service first. A hit vector marks every trigger that took part in the firing so that the register bank can set the hit flags. All outputs are registered, so they appear on the clock edge after the match inputs are sampled.

Build-time parameters set the trigger count. They also decide whether both actions may be taken for one instruction, which action comes first, and whether a machine-mode-only core gates breakpoint-action triggers while interrupts are globally disabled.

Top module: `trig_fire`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `hit_o`, `bkpt_o`, `dbg_o` and `order_o` are all 0.
- R2: If `dbg_mode_i` is 1 in a cycle, then in the following cycle `hit_o` is 0 and neither request is raised.
- R3: Class codes run from 0 (strongest) to 6 (weakest): 0 is exception/instruction-count/interrupt, 1 is the after-match of the previous instruction, 2 is execute address, 3 is execute data, 4 is load/store address, 5 is store data and 6 is load data. Only chains whose class equals the smallest code among all eligible chains fire. A chain whose class is 7 never fires.
- R4: Every trigger that belongs to a firing chain has its bit set in `hit_o`. This includes all triggers of several co-firing chains that share the winning class.
- R5: `link_i[k]=1` joins trigger k with trigger k+1, and the link bit of the last trigger is ignored. A chain is a candidate only when all of its members match in the same cycle. The chain takes the action of its highest-numbered member.
- R6: The class of a chain is the largest code held by any of its members.
- R7: `act_i[k]=0` selects a breakpoint exception and `act_i[k]=1` selects Debug Mode entry. `bkpt_o` and `dbg_o` are registered and appear one cycle after the match inputs that cause them.
- R8: With `BOTH_ACTIONS=1`, winning chains of both actions raise `bkpt_o` and `dbg_o` together. `order_o` is 1 in that cycle exactly when `DEBUG_FIRST=1` (1 means debug entry first), and `order_o` is 0 whenever only one request is raised.
- R9: With `BOTH_ACTIONS=0`, winning chains of both actions raise only `dbg_o`. The breakpoint is dropped, but `hit_o` still marks the breakpoint chain's triggers.
- R10: With `MONLY_GATE=1`, `priv_i=2'b11` and `mie_i=0`, chains whose action is breakpoint do not fire and set no hit bits. Debug-action chains are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| match_i | input | N_TRIG | Comparator match per trigger |
| link_i | input | N_TRIG | Link trigger k to trigger k+1 |
| act_i | input | N_TRIG | Action per trigger: 0 breakpoint, 1 debug entry |
| cls_i | input | N_TRIG x 3 | Priority class code per trigger |
| priv_i | input | 2 | Current privilege level, 2'b11 = machine |
| dbg_mode_i | input | 1 | Hart is in Debug Mode |
| mie_i | input | 1 | Global machine interrupt enable |
| bkpt_o | output | 1 | Breakpoint exception request pulse |
| dbg_o | output | 1 | Debug Mode entry request pulse |
| order_o | output | 1 | With both requests: 1 = debug entry first |
| hit_o | output | N_TRIG | Triggers whose hit flag must be set |

## Verification
The checker confirms a set of properties on every cycle. Debug Mode and the machine-mode gate block firing in the cycle after they are seen. A request is raised only together with a hit, and a hit only together with a request. Hit bits fall only on triggers that matched in the previous cycle. `order_o` never stands without both requests, and both requests never stand together when dual action is disabled. The bench's sweeps alone can show which class wins, how chains combine their matches, classes and actions, and that every co-firing trigger is marked. They do this by comparing two differently configured instances against a model computed trigger by trigger.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int CLS_W   = 3;
    localparam int NUM_CLS = 7;
    typedef logic [CLS_W-1:0] cls_t;

    // class codes, strongest first; order is behaviour
    localparam cls_t CLS_EVT_CNT_IRQ = 3'd0;
    localparam cls_t CLS_AFTER_PREV  = 3'd1;
    localparam cls_t CLS_EXEC_ADDR   = 3'd2;
    localparam cls_t CLS_EXEC_DATA   = 3'd3;
    localparam cls_t CLS_LDST_ADDR   = 3'd4;
    localparam cls_t CLS_ST_DATA     = 3'd5;
    localparam cls_t CLS_LD_DATA     = 3'd6;
    localparam cls_t CLS_NONE        = 3'd7;

    localparam logic ACT_BRK = 1'b0;
    localparam logic ACT_DBG = 1'b1;

    localparam logic [1:0] PRIV_MACH = 2'b11;
endpackage

// File: rtl/trig_chain.sv
module trig_chain
    import trig_pkg::*;
#(
    parameter int N_TRIG = 4
) (
    input  logic [N_TRIG-1:0]            match_i,
    input  logic [N_TRIG-1:0]            link_i,
    input  logic [N_TRIG-1:0]            act_i,
    input  logic [N_TRIG-1:0][CLS_W-1:0] cls_i,
    output logic [N_TRIG-1:0]            grp_match_o,
    output logic [N_TRIG-1:0]            grp_act_o,
    output logic [N_TRIG-1:0][CLS_W-1:0] grp_cls_o
);
    // Backward pass folds each trigger with everything up to the chain tail,
    // forward pass copies the head's result onto every member.
    always_comb begin
        logic [N_TRIG-1:0]            linked;
        logic [N_TRIG-1:0]            all_b;
        logic [N_TRIG-1:0]            act_b;
        logic [N_TRIG-1:0][CLS_W-1:0] max_b;

        for (int i = 0; i < N_TRIG; i++) begin
            linked[i] = (i < N_TRIG - 1) ? link_i[i] : 1'b0;
        end

        all_b[N_TRIG-1] = match_i[N_TRIG-1];
        act_b[N_TRIG-1] = act_i[N_TRIG-1];
        max_b[N_TRIG-1] = cls_i[N_TRIG-1];
        for (int i = N_TRIG - 2; i >= 0; i--) begin
            if (linked[i]) begin
                all_b[i] = match_i[i] & all_b[i+1];
                act_b[i] = act_b[i+1];
                max_b[i] = (cls_i[i] > max_b[i+1]) ? cls_i[i] : max_b[i+1];
            end else begin
                all_b[i] = match_i[i];
                act_b[i] = act_i[i];
                max_b[i] = cls_i[i];
            end
        end

        grp_match_o[0] = all_b[0];
        grp_act_o[0]   = act_b[0];
        grp_cls_o[0]   = max_b[0];
        for (int i = 1; i < N_TRIG; i++) begin
            if (linked[i-1]) begin
                grp_match_o[i] = grp_match_o[i-1];
                grp_act_o[i]   = grp_act_o[i-1];
                grp_cls_o[i]   = grp_cls_o[i-1];
            end else begin
                grp_match_o[i] = all_b[i];
                grp_act_o[i]   = act_b[i];
                grp_cls_o[i]   = max_b[i];
            end
        end
    end
endmodule

// File: rtl/trig_arb.sv
module trig_arb
    import trig_pkg::*;
#(
    parameter int N_TRIG = 4
) (
    input  logic [N_TRIG-1:0]            elig_i,
    input  logic [N_TRIG-1:0][CLS_W-1:0] cls_i,
    output logic [N_TRIG-1:0]            win_o
);
    logic [NUM_CLS-1:0] present;
    cls_t               best;
    logic               any;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        always_comb begin
            present[c] = 1'b0;
            for (int k = 0; k < N_TRIG; k++) begin
                if (elig_i[k] && (cls_i[k] == cls_t'(c))) present[c] = 1'b1;
            end
        end
    end

    always_comb begin
        best = CLS_NONE;
        any  = 1'b0;
        for (int c = NUM_CLS - 1; c >= 0; c--) begin
            if (present[c]) begin
                best = cls_t'(c);
                any  = 1'b1;
            end
        end
    end

    for (genvar k = 0; k < N_TRIG; k++) begin : g_win
        assign win_o[k] = any & elig_i[k] & (cls_i[k] == best);
    end
endmodule

// File: rtl/trig_fire.sv
module trig_fire
    import trig_pkg::*;
#(
    parameter int N_TRIG       = 4,
    parameter bit BOTH_ACTIONS = 1'b1,
    parameter bit DEBUG_FIRST  = 1'b1,
    parameter bit MONLY_GATE   = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_TRIG-1:0]            match_i,
    input  logic [N_TRIG-1:0]            link_i,
    input  logic [N_TRIG-1:0]            act_i,
    input  logic [N_TRIG-1:0][CLS_W-1:0] cls_i,
    input  logic [1:0]                   priv_i,
    input  logic                         dbg_mode_i,
    input  logic                         mie_i,
    output logic                         bkpt_o,
    output logic                         dbg_o,
    output logic                         order_o,
    output logic [N_TRIG-1:0]            hit_o
);
    typedef struct packed {
        logic [N_TRIG-1:0] hit;
        logic              bkpt;
        logic              dbg;
        logic              order;
    } fire_t;

    fire_t st_d, st_q;

    logic [N_TRIG-1:0]            grp_match;
    logic [N_TRIG-1:0]            grp_act;
    logic [N_TRIG-1:0][CLS_W-1:0] grp_cls;
    logic [N_TRIG-1:0]            elig;
    logic [N_TRIG-1:0]            win;

    trig_chain #(.N_TRIG(N_TRIG)) u_chain (
        .match_i     (match_i),
        .link_i      (link_i),
        .act_i       (act_i),
        .cls_i       (cls_i),
        .grp_match_o (grp_match),
        .grp_act_o   (grp_act),
        .grp_cls_o   (grp_cls)
    );

    always_comb begin
        logic mgate;
        mgate = MONLY_GATE && (priv_i == PRIV_MACH) && !mie_i;
        for (int k = 0; k < N_TRIG; k++) begin
            elig[k] = grp_match[k] && (grp_cls[k] != CLS_NONE) && !dbg_mode_i
                      && !(mgate && (grp_act[k] == ACT_BRK));
        end
    end

    trig_arb #(.N_TRIG(N_TRIG)) u_arb (
        .elig_i (elig),
        .cls_i  (grp_cls),
        .win_o  (win)
    );

    always_comb begin
        logic brk_any, dbg_any;
        brk_any    = |(win & ~grp_act);
        dbg_any    = |(win & grp_act);
        st_d.hit   = win;
        st_d.dbg   = dbg_any;
        st_d.bkpt  = brk_any && (BOTH_ACTIONS || !dbg_any);
        st_d.order = DEBUG_FIRST && st_d.bkpt && dbg_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o   = st_q.hit;
    assign bkpt_o  = st_q.bkpt;
    assign dbg_o   = st_q.dbg;
    assign order_o = st_q.order;
endmodule

// File: rtl/trig_fire_chk.sv
module trig_fire_chk #(
    parameter int N_TRIG       = 4,
    parameter bit BOTH_ACTIONS = 1'b1,
    parameter bit MONLY_GATE   = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_TRIG-1:0] match_i,
    input logic [1:0]        priv_i,
    input logic              dbg_mode_i,
    input logic              mie_i,
    input logic              bkpt_o,
    input logic              dbg_o,
    input logic              order_o,
    input logic [N_TRIG-1:0] hit_o
);
    p_quiet_in_debug_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode_i |=> (hit_o == '0) && !bkpt_o && !dbg_o);

    // R4 / R7: a request always comes with hit bits, and the reverse
    p_req_has_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bkpt_o || dbg_o) |-> (hit_o != '0));
    p_hit_has_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o != '0) |-> (bkpt_o || dbg_o));

    // R5: a hit bit needs that trigger's match one cycle earlier
    p_hit_from_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o & ~$past(match_i)) == '0);

    p_order_with_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        order_o |-> (bkpt_o && dbg_o));

    if (!BOTH_ACTIONS) begin : g_single
        p_debug_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(bkpt_o && dbg_o));
    end

    if (MONLY_GATE) begin : g_gate
        p_mgate_no_brk_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ((priv_i == 2'b11) && !mie_i) |=> !bkpt_o);
    end
endmodule

bind trig_fire trig_fire_chk #(
    .N_TRIG       (N_TRIG),
    .BOTH_ACTIONS (BOTH_ACTIONS),
    .MONLY_GATE   (MONLY_GATE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .match_i    (match_i),
    .priv_i     (priv_i),
    .dbg_mode_i (dbg_mode_i),
    .mie_i      (mie_i),
    .bkpt_o     (bkpt_o),
    .dbg_o      (dbg_o),
    .order_o    (order_o),
    .hit_o      (hit_o)
);

// File: tb/sim_trig_fire.sv
module sim_trig_fire;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       match, link, act;
    logic [2:0][2:0]  cls;
    logic [1:0]       priv;
    logic             dmode, mie;
    logic             bk0, db0, or0, bk1, db1, or1;
    logic [2:0]       hit0, hit1;
    int               nchk = 0;
    int               nfail = 0;

    always #5 clk = ~clk;

    // u0: both actions, debug first, machine gate on
    trig_fire #(.N_TRIG(3), .BOTH_ACTIONS(1'b1), .DEBUG_FIRST(1'b1), .MONLY_GATE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .match_i(match), .link_i(link), .act_i(act),
        .cls_i(cls), .priv_i(priv), .dbg_mode_i(dmode), .mie_i(mie),
        .bkpt_o(bk0), .dbg_o(db0), .order_o(or0), .hit_o(hit0));
    // u1: debug only on conflict, breakpoint first, no gate
    trig_fire #(.N_TRIG(3), .BOTH_ACTIONS(1'b0), .DEBUG_FIRST(1'b0), .MONLY_GATE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .match_i(match), .link_i(link), .act_i(act),
        .cls_i(cls), .priv_i(priv), .dbg_mode_i(dmode), .mie_i(mie),
        .bkpt_o(bk1), .dbg_o(db1), .order_o(or1), .hit_o(hit1));

    // returns {order, dbg, bkpt, hit[2:0]}
    function automatic logic [5:0] model(logic [2:0] m, logic [2:0] lk, logic [2:0] ac,
                                         logic [2:0][2:0] cl, logic dm, logic [1:0] pv,
                                         logic ie, bit both, bit dfirst, bit gate);
        logic [2:0] el, ht;
        int ec[3], tl[3];
        int best = 8;
        logic bq = 1'b0, dq = 1'b0, bo;
        for (int k = 0; k < 3; k++) begin
            int h = k, t = k, mx = 0;
            logic ok = 1'b1;
            while (h > 0 && lk[h-1]) h--;
            while (t < 2 && lk[t]) t++;
            for (int j = h; j <= t; j++) begin
                ok = ok & m[j];
                if (int'(cl[j]) > mx) mx = int'(cl[j]);
            end
            ec[k] = mx; tl[k] = t;
            el[k] = ok && mx != 7 && !dm && !(gate && pv == 2'b11 && !ie && ac[t] == 1'b0);
            if (el[k] && mx < best) best = mx;
        end
        for (int k = 0; k < 3; k++) begin
            ht[k] = el[k] && ec[k] == best;
            if (ht[k] && !ac[tl[k]]) bq = 1'b1;
            if (ht[k] && ac[tl[k]])  dq = 1'b1;
        end
        bo = bq && (both || !dq);
        return {dfirst && bo && dq, dq, bo, ht};
    endfunction

    task automatic chk(string tag, logic [5:0] got, logic [5:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got {order,dbg,bkpt,hit}=%b expected %b", tag, got, exp);
        end
    endtask

    task automatic apply(logic [2:0] m, logic [2:0] lk, logic [2:0] ac, logic [2:0][2:0] cl,
                         logic dm, logic [1:0] pv, logic ie);
        match = m; link = lk; act = ac; cls = cl; dmode = dm; priv = pv; mie = ie;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        match = '0; link = '0; act = '0; cls = '0; priv = 2'b11; dmode = 1'b0; mie = 1'b1;
        @(negedge clk);
        match = 3'b111; act = 3'b011;
        @(negedge clk);
        chk("R1 in reset u0", {or0, db0, bk0, hit0}, 6'b0);
        chk("R1 in reset u1", {or1, db1, bk1, hit1}, 6'b0);
        @(negedge clk);
        rst_n = 1'b1; match = '0;
        @(posedge clk); @(negedge clk);
        chk("R1 after reset", {or0, db0, bk0, hit0}, 6'b0);

        // R2: everything matches but hart is in Debug Mode
        apply(3'b111, 3'b000, 3'b010, '{3'd0, 3'd0, 3'd0}, 1'b1, 2'b11, 1'b1);
        chk("R2 debug mode u0", {or0, db0, bk0, hit0}, 6'b0);
        // R3: class 2 beats class 5; cls index [2],[1],[0]
        apply(3'b011, 3'b000, 3'b001, '{3'd0, 3'd2, 3'd5}, 1'b0, 2'b00, 1'b0);
        chk("R3 strongest class wins", {or0, db0, bk0, hit0}, 6'b001_010);
        apply(3'b100, 3'b000, 3'b100, '{3'd7, 3'd0, 3'd0}, 1'b0, 2'b00, 1'b0);
        chk("R3 class 7 never fires", {or0, db0, bk0, hit0}, 6'b0);
        // R5: chain 0-1 needs both members
        apply(3'b001, 3'b001, 3'b010, '{3'd0, 3'd1, 3'd1}, 1'b0, 2'b00, 1'b0);
        chk("R5 partial chain", {or0, db0, bk0, hit0}, 6'b0);
        apply(3'b011, 3'b001, 3'b010, '{3'd0, 3'd1, 3'd1}, 1'b0, 2'b00, 1'b0);
        chk("R5 full chain, tail action", {or0, db0, bk0, hit0}, 6'b010_011);
        // R6: chain class 6 loses to lone class 3
        apply(3'b111, 3'b001, 3'b000, '{3'd3, 3'd0, 3'd6}, 1'b0, 2'b00, 1'b0);
        chk("R6 chain takes weakest class", {or0, db0, bk0, hit0}, 6'b001_100);
        // R4 R8 R9: same class, both actions
        apply(3'b011, 3'b000, 3'b010, '{3'd0, 3'd4, 3'd4}, 1'b0, 2'b00, 1'b0);
        chk("R8 both, debug first u0", {or0, db0, bk0, hit0}, 6'b111_011);
        chk("R9 debug only u1, R4 hits", {or1, db1, bk1, hit1}, 6'b010_011);
        // R7: one-cycle pulse
        apply(3'b000, 3'b000, 3'b000, '{3'd0, 3'd0, 3'd0}, 1'b0, 2'b00, 1'b0);
        chk("R7 pulse ends", {or0, db0, bk0, hit0}, 6'b0);
        // R10: machine mode, interrupts off
        apply(3'b011, 3'b000, 3'b010, '{3'd0, 3'd1, 3'd1}, 1'b0, 2'b11, 1'b0);
        chk("R10 gate drops breakpoint u0", {or0, db0, bk0, hit0}, 6'b010_010);
        chk("R10 no gate u1", {or1, db1, bk1, hit1}, 6'b010_011);

        // sweep: R2 R3 R4 R5 R6 R7 R8 R9 R10 against the trigger-by-trigger model
        for (int md = 0; md < 4; md++)
        for (int m = 0; m < 8; m++)
        for (int l = 0; l < 4; l++)
        for (int a = 0; a < 8; a++)
        for (int c = 0; c < 64; c++) begin
            logic [2:0][2:0] cl;
            logic [2:0] lk;
            logic dm, ie;
            logic [1:0] pv;
            for (int k = 0; k < 3; k++) begin
                case ((c >> (2 * k)) & 3)
                    0: cl[k] = 3'd0;
                    1: cl[k] = 3'd2;
                    2: cl[k] = 3'd5;
                    default: cl[k] = 3'd7;
                endcase
            end
            lk = {m[0] ^ a[1], l[1:0]};
            dm = (md == 3);
            pv = (md == 2) ? 2'b00 : 2'b11;
            ie = (md == 0 || md == 3);
            apply(3'(m), lk, 3'(a), cl, dm, pv, ie);
            chk("R4/R8/R10 sweep u0", {or0, db0, bk0, hit0},
                model(3'(m), lk, 3'(a), cl, dm, pv, ie, 1'b1, 1'b1, 1'b1));
            chk("R3/R5/R9 sweep u1", {or1, db1, bk1, hit1},
                model(3'(m), lk, 3'(a), cl, dm, pv, ie, 1'b0, 1'b0, 1'b0));
        end
        report();
    end
endmodule